// File: doc/BRIEF.md
# I2C Byte-Event Interrupt and Clock-Stretch Controller

This block works next to an I2C shift register and bit counter. On each synchronized SCL falling-edge strobe it checks the transfer phase, the bus role and a wait-timing select. From these it decides two things: whether to raise a byte-event interrupt, and whether to hold SCL low. Holding SCL low stretches the clock until software responds. Bit-level SDA shifting and the detection of START and STOP conditions are done elsewhere.

For data bytes, in either direction, the interrupt and the stretch come on the 8th or the 9th clock, as the wait-timing select chooses. In the address phase the point is fixed by the role and by what the address turned out to be:
- A master always uses the 9th clock.
- A slave whose own address matched uses the 9th clock, and the ACK is forced.
- A slave that received an extension code uses the 8th clock.
- A slave that sees a mismatch after a repeated start gets the interrupt on the 9th clock, with no stretch.
- In every other address case nothing happens.

Software ends a stretch with a data write or a wait-release command. In master role a start or stop request also ends it. The ACK level for the 9th clock is frozen while a stretch is pending and is taken from the ACK-enable input at the moment of release.

Top module: `i2c_evt_wait`

## Requirements
- R1: In the data phase (addr_phase=0) a strobe with bit_cnt=8 raises irq and scl_hold when wait_sel=0, and a strobe with bit_cnt=9 does so when wait_sel=1. A strobe at the other count does nothing.
- R2: In the address phase as master (is_master=1), irq and scl_hold are raised only on the bit_cnt=9 strobe, whatever wait_sel is.
- R3: In the address phase as slave with addr_match=1, irq and scl_hold are raised only on the bit_cnt=9 strobe, whatever wait_sel is.
- R4: While slave, address phase and addr_match are all 1, force_ack and ack_drive are 1 even when ack_en=0.
- R5: In the address phase as slave with addr_match=0 and ext_code=1, irq and scl_hold are raised on the bit_cnt=8 strobe and not on the bit_cnt=9 strobe.
- R6: In the address phase as slave with addr_match=0, ext_code=0 and restart_seen=1, the bit_cnt=9 strobe raises irq without scl_hold.
- R7: In the address phase as slave with addr_match, ext_code and restart_seen all 0, no strobe raises irq or scl_hold.
- R8: While scl_hold=1, a wr_data or wait_rel pulse clears scl_hold on the next clock edge.
- R9: start_req and stop_req clear a pending scl_hold only when is_master=1. In slave role they leave it set.
- R10: A release pulse while scl_hold=0 has no lasting effect. A later event still sets scl_hold, and scl_hold stays set until the next release.
- R11: A stop_det pulse raises irq only when stop_ie=1.
- R12: While scl_hold=1, ack_drive keeps its latched value even if ack_en changes. On release it takes the ack_en value present with the release pulse.
- R13: All outputs are 0 during reset. irq is registered: it is a one-cycle pulse appearing one clock after the triggering input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_fall | input | 1 | Synchronized SCL falling-edge strobe |
| bit_cnt | input | CNT_W | Number of the clock whose falling edge the strobe marks (8 or 9 matter) |
| wait_sel | input | 1 | Wait-timing select: 0 = 8th clock, 1 = 9th clock |
| is_master | input | 1 | 1 = master role, 0 = slave |
| addr_phase | input | 1 | Current byte is the address byte |
| addr_match | input | 1 | Received address equals own address |
| ext_code | input | 1 | Received address is an extension code |
| restart_seen | input | 1 | A repeated start preceded this address |
| ack_en | input | 1 | Software ACK enable |
| wr_data | input | 1 | Shift-register write pulse (release) |
| wait_rel | input | 1 | Wait-release command pulse |
| start_req | input | 1 | Start-condition request pulse (master release) |
| stop_req | input | 1 | Stop-condition request pulse (master release) |
| stop_det | input | 1 | Stop-condition detected strobe |
| stop_ie | input | 1 | Stop interrupt enable |
| irq | output | 1 | Byte-event interrupt pulse |
| scl_hold | output | 1 | Request to hold SCL low |
| force_ack | output | 1 | ACK forced by slave address match |
| ack_drive | output | 1 | ACK level to drive on the 9th clock |

## Verification
The strobe count is stepped across 8 and 9 in five settings:
- the data phase under both wait-select values;
- the master address phase;
- the slave address phase with a match;
- the slave address phase with an extension code;
- the slave address phase with a mismatch after a restart, and with none of these.

Each setting shows which count is the active one and whether a stretch goes with the interrupt. Release pulses are applied in both roles, and also with no stretch pending. This separates the release paths that are always honoured from those honoured only in master role. ACK-enable changes made during and after a stretch show that the level is frozen until release.

// File: rtl/i2c_evt_wait.sv
module i2c_evt_wait #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_fall,
  input  logic [CNT_W-1:0] bit_cnt,
  input  logic             wait_sel,
  input  logic             is_master,
  input  logic             addr_phase,
  input  logic             addr_match,
  input  logic             ext_code,
  input  logic             restart_seen,
  input  logic             ack_en,
  input  logic             wr_data,
  input  logic             wait_rel,
  input  logic             start_req,
  input  logic             stop_req,
  input  logic             stop_det,
  input  logic             stop_ie,
  output logic             irq,
  output logic             scl_hold,
  output logic             force_ack,
  output logic             ack_drive
);
  localparam logic [CNT_W-1:0] CLK8 = CNT_W'(8);
  localparam logic [CNT_W-1:0] CLK9 = CNT_W'(9);

  logic at8, at9, slave_addr;
  logic slv_match, slv_ext, slv_rs;
  logic ev_wait, ev_nowait, release_evt, ack_lat;

  assign at8        = scl_fall && (bit_cnt == CLK8);
  assign at9        = scl_fall && (bit_cnt == CLK9);
  assign slave_addr = addr_phase && !is_master;
  assign slv_match  = slave_addr && addr_match;
  assign slv_ext    = slave_addr && !addr_match && ext_code;
  assign slv_rs     = slave_addr && !addr_match && !ext_code && restart_seen;

  assign ev_wait = (!addr_phase && (wait_sel ? at9 : at8))
                 || (addr_phase && is_master && at9)
                 || (slv_match && at9)
                 || (slv_ext && at8);
  assign ev_nowait = slv_rs && at9;

  assign release_evt = wr_data || wait_rel || (is_master && (start_req || stop_req));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq      <= 1'b0;
      scl_hold <= 1'b0;
      ack_lat  <= 1'b0;
    end else begin
      irq <= ev_wait || ev_nowait || (stop_det && stop_ie);
      if (ev_wait)
        scl_hold <= 1'b1;
      else if (release_evt)
        scl_hold <= 1'b0;
      if (!scl_hold || release_evt)
        ack_lat <= ack_en;
    end
  end

  assign force_ack = slv_match;
  assign ack_drive = force_ack || ack_lat;
endmodule

module i2c_evt_wait_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic is_master,
  input logic addr_phase,
  input logic addr_match,
  input logic ext_code,
  input logic wr_data,
  input logic wait_rel,
  input logic stop_det,
  input logic stop_ie,
  input logic irq,
  input logic scl_hold,
  input logic force_ack,
  input logic ack_drive
);
  assert_irq_cause_R13: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(scl_fall || (stop_det && stop_ie)));

  assert_hold_with_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_hold) |-> irq);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && (wr_data || wait_rel) && !scl_fall) |=> !scl_hold);

  assert_slave_keeps_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_hold && !is_master && !wr_data && !wait_rel) |=> scl_hold);

  assert_stop_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !stop_ie && !scl_fall) |=> !irq);

  assert_no_wait_mismatch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && addr_phase && !is_master && !addr_match && !ext_code) |=> !$rose(scl_hold));

  assert_forced_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_phase && !is_master && addr_match) |-> (force_ack && ack_drive));
endmodule

bind i2c_evt_wait i2c_evt_wait_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .is_master(is_master),
  .addr_phase(addr_phase), .addr_match(addr_match), .ext_code(ext_code),
  .wr_data(wr_data), .wait_rel(wait_rel), .stop_det(stop_det), .stop_ie(stop_ie),
  .irq(irq), .scl_hold(scl_hold), .force_ack(force_ack), .ack_drive(ack_drive)
);

// File: tb/test_i2c_evt_wait.sv
module test_i2c_evt_wait;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_fall = 0, wait_sel = 0, is_master = 0, addr_phase = 0;
  logic addr_match = 0, ext_code = 0, restart_seen = 0, ack_en = 0;
  logic wr_data = 0, wait_rel = 0, start_req = 0, stop_req = 0;
  logic stop_det = 0, stop_ie = 0;
  logic [3:0] bit_cnt = 4'd0;
  logic irq, scl_hold, force_ack, ack_drive;

  always #4 clk = ~clk;

  i2c_evt_wait #(.CNT_W(4)) i_i2c_evt_wait (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .bit_cnt(bit_cnt),
    .wait_sel(wait_sel), .is_master(is_master), .addr_phase(addr_phase),
    .addr_match(addr_match), .ext_code(ext_code), .restart_seen(restart_seen),
    .ack_en(ack_en), .wr_data(wr_data), .wait_rel(wait_rel),
    .start_req(start_req), .stop_req(stop_req), .stop_det(stop_det),
    .stop_ie(stop_ie), .irq(irq), .scl_hold(scl_hold),
    .force_ack(force_ack), .ack_drive(ack_drive)
  );

  typedef struct {
    logic  e_irq;
    logic  e_hold;
    logic  e_ack;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq !== e.e_irq || scl_hold !== e.e_hold || ack_drive !== e.e_ack) begin
        errors++;
        $display("FAIL %s: irq/hold/ack = %0b%0b%0b expected %0b%0b%0b",
                 e.tag, irq, scl_hold, ack_drive, e.e_irq, e.e_hold, e.e_ack);
      end
    end
  end

  task automatic tick(input logic ei, input logic eh, input logic ea, input string tag);
    exp_t e;
    e.e_irq = ei; e.e_hold = eh; e.e_ack = ea; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
    scl_fall = 0; wr_data = 0; wait_rel = 0;
    start_req = 0; stop_req = 0; stop_det = 0;
  endtask

  task automatic fall(input logic [3:0] n);
    scl_fall = 1; bit_cnt = n;
  endtask

  initial begin
    #40000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(0, 0, 0, "R13 reset state");
    rst_n = 1;
    fall(7);  tick(0, 0, 0, "R1 data ws0 cnt7");
    fall(8);  tick(1, 1, 0, "R1 data ws0 8th");
    tick(0, 1, 0, "R13 irq single pulse");
    ack_en = 1; tick(0, 1, 0, "R12 ack frozen during hold");
    wr_data = 1; tick(0, 0, 1, "R8 wr_data release, R12 ack latched");
    ack_en = 0; tick(0, 0, 0, "R12 ack follows when idle");
    fall(9);  tick(0, 0, 0, "R1 data ws0 9th ignored");
    wait_sel = 1;
    fall(8);  tick(0, 0, 0, "R1 data ws1 8th ignored");
    fall(9);  tick(1, 1, 0, "R1 data ws1 9th");
    wait_rel = 1; tick(0, 0, 0, "R8 wait_rel release");
    fall(9);  tick(1, 1, 0, "R1 slave data 9th");
    start_req = 1; stop_req = 1; tick(0, 1, 0, "R9 slave start/stop ignored");
    wait_rel = 1; tick(0, 0, 0, "R8 release after R9");
    is_master = 1;
    fall(9);  tick(1, 1, 0, "R1 master data 9th");
    start_req = 1; tick(0, 0, 0, "R9 master start releases");
    fall(9);  tick(1, 1, 0, "R1 master data 9th again");
    stop_req = 1; tick(0, 0, 0, "R9 master stop releases");
    wr_data = 1; tick(0, 0, 0, "R10 release with no hold");
    fall(9);  tick(1, 1, 0, "R10 later event still holds");
    tick(0, 1, 0, "R10 hold persists");
    wait_rel = 1; tick(0, 0, 0, "R8 release");
    addr_phase = 1; wait_sel = 0;
    fall(8);  tick(0, 0, 0, "R2 master addr no 8th");
    fall(9);  tick(1, 1, 0, "R2 master addr 9th");
    wait_rel = 1; tick(0, 0, 0, "R2 release");
    is_master = 0; addr_match = 1;
    tick(0, 0, 1, "R4 forced ack with ack_en=0");
    fall(8);  tick(0, 0, 1, "R3 slave match no 8th");
    fall(9);  tick(1, 1, 1, "R3 slave match 9th");
    wait_rel = 1; tick(0, 0, 1, "R3 release");
    addr_match = 0; ext_code = 1;
    fall(8);  tick(1, 1, 0, "R5 ext code 8th");
    wait_rel = 1; tick(0, 0, 0, "R5 release");
    fall(9);  tick(0, 0, 0, "R5 ext code not 9th");
    ext_code = 0; restart_seen = 1;
    fall(8);  tick(0, 0, 0, "R6 restart mismatch no 8th");
    fall(9);  tick(1, 0, 0, "R6 restart mismatch irq no hold");
    restart_seen = 0;
    fall(8);  tick(0, 0, 0, "R7 mismatch 8th");
    fall(9);  tick(0, 0, 0, "R7 mismatch 9th");
    stop_det = 1; tick(0, 0, 0, "R11 stop masked");
    stop_ie = 1; stop_det = 1; tick(1, 0, 0, "R11 stop enabled");
    tick(0, 0, 0, "R13 stop irq single");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule